// File: doc/BRIEF.md
# Cipher Interposer Control FSM

This block sits in the data path between a host that writes and then reads back blocks of 128-bit words and a counter-mode encryption engine. Plaintext from the host is buffered in a data FIFO while the host write strobe is high. When the write ends, the block runs the key-expansion step if it has not yet run since the last reset. It then lets the keystream generator fill a keystream FIFO. When the generator reports that pre-generation is finished and the host asks to read, the block pops both FIFOs together and XORs each pair of words. It emits the results one word per cycle.

The key-expansion unit and the keystream generator are modelled as simple ports. The block raises a level request toward the expansion unit and waits for its done pulse. It holds a run enable toward the generator and accepts pushed keystream words. When a read ends, keystream that was not used is discarded, so the next block of data never reuses a counter value. A sticky flag records that expansion has been done, and later transfers skip that step.

Top module: `cipher_interposer`

## Requirements
- R1: A synchronous reset, with `rst` high at a clock edge, sets `phase` to 0 (idle), clears `expandReq`, `genRun` and `outValid`, and clears the expansion-done flag, so the next write goes through key expansion.
- R2: In idle, `hostWrite` high moves `phase` to 1 (write) at the next edge. Every cycle with `hostWrite` high in idle or write stores `hostWrData` in the data FIFO, including the first cycle.
- R3: In write, `hostWrite` low with the expansion flag clear moves `phase` to 2 (key expansion), and `expandReq` is high for as long as that phase lasts.
- R4: In write, `hostWrite` low with the expansion flag set moves `phase` straight to 3 (keystream generation), and `expandReq` stays low.
- R5: In key expansion, `keyDone` high moves `phase` to 3 and sets the expansion flag.
- R6: In phase 3, `phase` moves to 4 (read) only at an edge where `genDone` and `hostRead` are both 1. Until then it stays at 3. `genRun` is high in phases 3 and 4.
- R7: In read, with `hostRead` high and both FIFOs holding data, one word is popped from each FIFO per cycle. One cycle later `outValid` is high and `outData` equals the data word XOR the keystream word, in FIFO order.
- R8: In read, if either FIFO is empty, neither FIFO is popped in that cycle and `outValid` is low in the next cycle.
- R9: In read, `hostRead` low moves `phase` to 0 at the next edge and empties the keystream FIFO. Keystream words pushed before that edge are never used for a later output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| hostWrite | input | 1 | Host write strobe |
| hostWrData | input | 128 | Plaintext word from host |
| hostRead | input | 1 | Host read strobe |
| expandReq | output | 1 | Request to key-expansion unit |
| keyDone | input | 1 | Key expansion finished |
| genRun | output | 1 | Keystream generator enable |
| genDone | input | 1 | Keystream pre-generation finished |
| ksPush | input | 1 | Keystream word valid |
| ksData | input | 128 | Keystream word |
| ksFull | output | 1 | Keystream FIFO full |
| outValid | output | 1 | Output word valid |
| outData | output | 128 | Data XOR keystream result |
| phase | output | 3 | Current phase: 0 idle, 1 write, 2 expand, 3 generate, 4 read |

## Verification
The XOR path is exercised with several distinct data and keystream patterns: all-ones, alternating bits, a single set bit and mixed words. These show that each output pairs the right two words in FIFO order and does not merely pass one operand through. A read that starts with fewer keystream words than data words checks that output stops until keystream arrives. Stale keystream left at the end of a read, followed by a second transfer that starts with an empty keystream FIFO, shows whether the flush took place. The second transfer and a later reset tell apart skipped expansion and repeated expansion.

// File: rtl/ci_pkg.sv
package ci_pkg;
  localparam int WORD_W = 128;

  typedef enum logic [2:0] {
    PH_IDLE   = 3'd0,
    PH_WRITE  = 3'd1,
    PH_EXPAND = 3'd2,
    PH_GEN    = 3'd3,
    PH_READ   = 3'd4
  } phase_t;

  typedef struct packed {
    logic dataPush;
    logic pop;
    logic ksFlush;
  } ctrlStrobes_t;
endpackage

// File: rtl/ci_fifo.sv
module ci_fifo #(
  parameter int WIDTH = 128,
  parameter int DEPTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic             pop,
  input  logic             flush,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout,
  output logic             empty,
  output logic             full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [AW:0] DEPTH_C = DEPTH[AW:0];

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0] wrPtr, rdPtr;
  logic [AW:0] count;
  logic doPush, doPop;

  assign empty  = (count == '0);
  assign full   = (count == DEPTH_C);
  assign doPush = push && !full;
  assign doPop  = pop && !empty;
  assign dout   = mem[rdPtr];

  function automatic logic [AW-1:0] nextPtr(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (doPush) begin
        mem[wrPtr] <= din;
        wrPtr <= nextPtr(wrPtr);
      end
      if (doPop) rdPtr <= nextPtr(rdPtr);
      count <= count + (doPush ? 1'b1 : 1'b0) - (doPop ? 1'b1 : 1'b0);
    end
  end
endmodule

// File: rtl/ci_ctrl.sv
module ci_ctrl
  import ci_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  logic         hostWrite,
  input  logic         hostRead,
  input  logic         keyDone,
  input  logic         genDone,
  input  logic         dataFull,
  input  logic         dataEmpty,
  input  logic         ksEmpty,
  output logic         expandReq,
  output logic         genRun,
  output ctrlStrobes_t strb,
  output phase_t       state
);
  phase_t nextState;
  logic expFlag;

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= PH_IDLE;
      expFlag <= 1'b0;
    end else begin
      state <= nextState;
      if (state == PH_EXPAND && keyDone) expFlag <= 1'b1;
    end
  end

  always_comb begin
    nextState = state;
    unique case (state)
      PH_IDLE:   if (hostWrite) nextState = PH_WRITE;
      PH_WRITE:  if (!hostWrite) nextState = expFlag ? PH_GEN : PH_EXPAND;
      PH_EXPAND: if (keyDone) nextState = PH_GEN;
      PH_GEN:    if (genDone && hostRead) nextState = PH_READ;
      PH_READ:   if (!hostRead) nextState = PH_IDLE;
      default:   nextState = PH_IDLE;
    endcase
  end

  assign expandReq     = (state == PH_EXPAND);
  assign genRun        = (state == PH_GEN) || (state == PH_READ);
  assign strb.dataPush = hostWrite && !dataFull &&
                         ((state == PH_IDLE) || (state == PH_WRITE));
  assign strb.pop      = (state == PH_READ) && hostRead && !dataEmpty && !ksEmpty;
  assign strb.ksFlush  = (state == PH_READ) && !hostRead;

  a_r3_expand_first: assert property (@(posedge clk) disable iff (rst)
    (state == PH_WRITE && !hostWrite && !expFlag) |=> (state == PH_EXPAND));
  a_r4_skip_expand: assert property (@(posedge clk) disable iff (rst)
    (state == PH_WRITE && !hostWrite && expFlag) |=> (state == PH_GEN && !expandReq));
  a_r5_expand_done: assert property (@(posedge clk) disable iff (rst)
    (state == PH_EXPAND && keyDone) |=> (state == PH_GEN && expFlag));
  a_r6_read_gate: assert property (@(posedge clk) disable iff (rst)
    (state == PH_GEN && !(genDone && hostRead)) |=> (state == PH_GEN));
  a_r9_leave_read: assert property (@(posedge clk) disable iff (rst)
    (state == PH_READ && !hostRead) |=> (state == PH_IDLE));
endmodule

// File: rtl/ci_datapath.sv
module ci_datapath
  import ci_pkg::*;
#(
  parameter int DATA_DEPTH = 16,
  parameter int KS_DEPTH   = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  ctrlStrobes_t      strb,
  input  logic [WORD_W-1:0] hostWrData,
  input  logic              ksPush,
  input  logic [WORD_W-1:0] ksData,
  output logic              dataFull,
  output logic              dataEmpty,
  output logic              ksEmpty,
  output logic              ksFull,
  output logic              outValid,
  output logic [WORD_W-1:0] outData
);
  logic [WORD_W-1:0] dataHead, ksHead;

  ci_fifo #(.WIDTH(WORD_W), .DEPTH(DATA_DEPTH)) uData (
    .clk(clk), .rst(rst), .push(strb.dataPush), .pop(strb.pop), .flush(1'b0),
    .din(hostWrData), .dout(dataHead), .empty(dataEmpty), .full(dataFull));

  ci_fifo #(.WIDTH(WORD_W), .DEPTH(KS_DEPTH)) uKs (
    .clk(clk), .rst(rst), .push(ksPush), .pop(strb.pop), .flush(strb.ksFlush),
    .din(ksData), .dout(ksHead), .empty(ksEmpty), .full(ksFull));

  always_ff @(posedge clk) begin
    if (rst) begin
      outValid <= 1'b0;
      outData  <= '0;
    end else begin
      outValid <= strb.pop;
      if (strb.pop) outData <= dataHead ^ ksHead;
    end
  end

  a_r8_pop_needs_both: assert property (@(posedge clk) disable iff (rst)
    strb.pop |-> (!dataEmpty && !ksEmpty));
  a_r9_flush_empties: assert property (@(posedge clk) disable iff (rst)
    strb.ksFlush |=> ksEmpty);
endmodule

// File: rtl/cipher_interposer.sv
module cipher_interposer
  import ci_pkg::*;
#(
  parameter int DATA_DEPTH = 16,
  parameter int KS_DEPTH   = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         hostWrite,
  input  logic [127:0] hostWrData,
  input  logic         hostRead,
  output logic         expandReq,
  input  logic         keyDone,
  output logic         genRun,
  input  logic         genDone,
  input  logic         ksPush,
  input  logic [127:0] ksData,
  output logic         ksFull,
  output logic         outValid,
  output logic [127:0] outData,
  output logic [2:0]   phase
);
  ctrlStrobes_t strb;
  phase_t state;
  logic dataFull, dataEmpty, ksEmpty;

  ci_ctrl uCtrl (
    .clk(clk), .rst(rst), .hostWrite(hostWrite), .hostRead(hostRead),
    .keyDone(keyDone), .genDone(genDone), .dataFull(dataFull),
    .dataEmpty(dataEmpty), .ksEmpty(ksEmpty), .expandReq(expandReq),
    .genRun(genRun), .strb(strb), .state(state));

  ci_datapath #(.DATA_DEPTH(DATA_DEPTH), .KS_DEPTH(KS_DEPTH)) uPath (
    .clk(clk), .rst(rst), .strb(strb), .hostWrData(hostWrData),
    .ksPush(ksPush), .ksData(ksData), .dataFull(dataFull),
    .dataEmpty(dataEmpty), .ksEmpty(ksEmpty), .ksFull(ksFull),
    .outValid(outValid), .outData(outData));

  assign phase = state;
endmodule

// File: tb/tb_cipher_interposer.sv
module tb_cipher_interposer;
  logic clk = 1'b0;
  logic rst, hostWrite, hostRead, keyDone, genDone, ksPush;
  logic [127:0] hostWrData, ksData;
  logic expandReq, genRun, ksFull, outValid;
  logic [127:0] outData;
  logic [2:0] phase;

  always #10 clk = ~clk;

  cipher_interposer dut (
    .clk(clk), .rst(rst), .hostWrite(hostWrite), .hostWrData(hostWrData),
    .hostRead(hostRead), .expandReq(expandReq), .keyDone(keyDone),
    .genRun(genRun), .genDone(genDone), .ksPush(ksPush), .ksData(ksData),
    .ksFull(ksFull), .outValid(outValid), .outData(outData), .phase(phase));

  localparam int NV = 6;
  localparam logic [127:0] DATA_V [NV] = '{
    {128{1'b1}}, {32{4'hA}}, 128'h1, 128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210,
    {64{2'b01}}, 128'hDEAD_BEEF_0000_FFFF_1234_0000_CAFE_0001};
  localparam logic [127:0] KS_V [NV] = '{
    {32{4'h5}}, {128{1'b1}}, 128'h8000_0000_0000_0000_0000_0000_0000_0000,
    128'h0F0F_0000_F0F0_FFFF_0000_1111_2222_3333,
    128'h1357_9BDF_0246_8ACE_FFFF_0000_AAAA_5555, 128'h0};
  localparam logic [127:0] STALE = 128'h5A5A_5A5A_0000_0000_FFFF_FFFF_1111_2222;

  int total = 0, bad = 0, monTotal = 0, monBad = 0, monIdx = 0;

  task automatic tick(); @(negedge clk); endtask

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && outValid) begin
      monTotal++;
      if (monIdx >= NV) begin
        monBad++;
        $display("FAIL R7 actual=%h expected=<no output>", outData);
      end else if (outData !== (DATA_V[monIdx] ^ KS_V[monIdx])) begin
        monBad++;
        $display("FAIL R7 actual=%h expected=%h", outData, DATA_V[monIdx] ^ KS_V[monIdx]);
      end
      monIdx++;
    end
  end

  initial begin
    #(20 * 100000);
    bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total + monTotal + 1, bad + monBad);
    $finish;
  end

  initial begin
    rst = 1; hostWrite = 0; hostRead = 0; keyDone = 0; genDone = 0; ksPush = 0;
    hostWrData = '0; ksData = '0;
    tick(); tick(); rst = 0;
    // R1 reset state
    check("R1 phase", 128'(phase), 128'd0);
    check("R1 outputs", {125'd0, expandReq, genRun, outValid}, 128'd0);

    // R2 write four words, starting from idle
    for (int i = 0; i < 4; i++) begin
      hostWrite = 1; hostWrData = DATA_V[i];
      tick();
      check("R2 write phase", 128'(phase), 128'd1);
    end
    hostWrite = 0;
    tick();
    check("R3 expand phase", 128'(phase), 128'd2);
    check("R3 expandReq", 128'(expandReq), 128'd1);
    tick();
    check("R3 holds expand", 128'(phase), 128'd2);
    keyDone = 1;
    tick(); keyDone = 0;
    check("R5 to generate", 128'(phase), 128'd3);
    check("R6 genRun", 128'(genRun), 128'd1);

    // keystream for only three words
    for (int i = 0; i < 3; i++) begin
      ksPush = 1; ksData = KS_V[i];
      tick();
    end
    ksPush = 0; hostRead = 1;
    tick();
    check("R6 no genDone stays", 128'(phase), 128'd3);
    hostRead = 0; genDone = 1;
    tick();
    check("R6 no read stays", 128'(phase), 128'd3);
    hostRead = 1;
    tick();
    check("R6 enter read", 128'(phase), 128'd4);
    repeat (6) tick();
    check("R8 stall after three", 128'(monIdx), 128'd3);
    check("R8 no output on stall", 128'(outValid), 128'd0);
    ksPush = 1; ksData = KS_V[3];
    tick(); ksPush = 0;
    tick(); tick();
    check("R7 fourth word", 128'(monIdx), 128'd4);

    // stale keystream left behind, then end read
    for (int i = 0; i < 2; i++) begin
      ksPush = 1; ksData = STALE ^ 128'(i);
      tick();
    end
    ksPush = 0;
    tick();
    hostRead = 0; genDone = 0;
    tick();
    check("R9 back to idle", 128'(phase), 128'd0);

    // second transfer: expansion skipped
    for (int i = 4; i < 6; i++) begin
      hostWrite = 1; hostWrData = DATA_V[i];
      tick();
    end
    hostWrite = 0;
    tick();
    check("R4 skip to generate", 128'(phase), 128'd3);
    check("R4 expandReq low", 128'(expandReq), 128'd0);
    genDone = 1; hostRead = 1;
    tick();
    check("R6 enter read again", 128'(phase), 128'd4);
    repeat (4) tick();
    check("R9 flushed no output", 128'(monIdx), 128'd4);
    for (int i = 4; i < 6; i++) begin
      ksPush = 1; ksData = KS_V[i];
      tick();
    end
    ksPush = 0;
    tick(); tick();
    check("R7 second transfer", 128'(monIdx), 128'd6);
    check("R7 ksFull low", 128'(ksFull), 128'd0);
    hostRead = 0; genDone = 0;
    tick();

    // R1 reset clears the expansion flag
    rst = 1; tick(); rst = 0;
    check("R1 reset phase", 128'(phase), 128'd0);
    hostWrite = 1; hostWrData = DATA_V[0];
    tick(); hostWrite = 0;
    tick();
    check("R1 flag cleared, expand again", 128'(phase), 128'd2);

    $display("  test done: total=%0d bad=%0d", total + monTotal, bad + monBad);
    $finish;
  end
endmodule